// File: doc/BRIEF.md
# Safeload Parameter Transfer Controller

The block stages up to five parameter updates, each made of a target address and a data word. It then commits them to a parameter RAM as one uninterrupted burst. Software fills the staging slots through a small register write port. It then sets a start bit in a 16-bit control register. The controller waits for the next frame-boundary strobe, so an update never lands part-way through a sample's processing. At that point it copies the staged words into the RAM, one write per clock.

Each slot carries a dirty flag, which is set when its data register is written. Only dirty slots are copied, in ascending slot order. When the burst completes, the hardware clears the start bit and all dirty flags together, and pulses a one-cycle completion strobe. Software can poll the start bit to detect completion. While a transfer is pending or running, the write port reports not-ready. The writer must then hold its request until ready returns, so a new staging write can never mix into the burst in progress.

Top module: `safeload_ctrl`

## Requirements
- R1: Each of the five slots has a 10-bit address register and a 28-bit data register. A write selects its register with `regSel`: bit 3 = 0 selects the address register of slot `regSel[2:0]`, and bit 3 = 1 selects the data register of that slot. Slot indices 5 to 7 (select values 5, 6, 7, 13, 14) are ignored. Select value 15 is the control register, which takes `regWrData[15:0]`.
- R2: A control write accepted in idle with bit 6 set starts a transfer, and `busy` is high from the next cycle.
- R3: When the transfer ends, the hardware clears control bit 6. In the same cycle it asserts `done` for one cycle and drops `busy`.
- R4: A slot is copied only if its data register was written after the last completed transfer. A slot whose address register alone was written produces no RAM write. All dirty flags are clear after completion.
- R5: The other 15 control bits keep their values when bit 6 self-clears. A control write with bit 6 clear only stores the value and starts nothing.
- R6: No RAM write occurs while the controller waits for a frame-boundary strobe. RAM writes happen only while `busy` is high.
- R7: Dirty slots are written in ascending slot order on consecutive clocks, one RAM write per clock. Each write carries the slot's address register on `ramAddr` and the slot's data register on `ramData`.
- R8: While `busy` is high, `regWrReady` is low and any write request is ignored. It neither changes the running transfer nor marks a slot dirty.
- R9: A start with no dirty slot completes at the next frame-boundary strobe with no RAM write, and still clears bit 6.
- R10: After reset the control register is 0x0000, `busy`, `done` and `ramWe` are low, and `regWrReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write request |
| regSel | input | 4 | Register select (slot address, slot data or control) |
| regWrData | input | 28 | Write value; low bits used for address and control |
| regWrReady | output | 1 | High when a write request is accepted |
| frameStrobe | input | 1 | Frame-boundary pulse that permits the burst |
| ctrlReg | output | 16 | Control register readback; bit 6 is the start bit |
| busy | output | 1 | Transfer pending or in progress |
| done | output | 1 | One-cycle pulse at transfer completion |
| ramWe | output | 1 | Parameter RAM write enable |
| ramAddr | output | 10 | Parameter RAM address |
| ramData | output | 28 | Parameter RAM write data |

## Verification
The hardest situation to reach from the ports is a write request that arrives while a transfer is pending. Its effect on the dirty flags is visible only through a later transfer. The bench starts a transfer with slot 0 dirty and holds back the frame strobe. It then drives a raw data write to slot 2 while `busy` is high, and checks that the burst carries only slot 0. A second start with no intervening write must then produce no RAM write, which shows that the blocked request left slot 2 clean.

// File: rtl/safeload_pkg.sv
package safeload_pkg;
  localparam int NUM_SLOTS = 5;
  localparam int ADDR_W    = 10;
  localparam int DATA_W    = 28;
  localparam int CTRL_W    = 16;
  localparam int START_BIT = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_COPY
  } xferState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;     // emit lowest dirty slot to RAM this cycle
    logic clearAll;  // end of transfer: drop every dirty flag
  } dpStrobe_t;
endpackage

// File: rtl/safeload_datapath.sv
module safeload_datapath
  import safeload_pkg::*;
#(
  parameter int NumSlots = NUM_SLOTS,
  parameter int AddrW    = ADDR_W,
  parameter int DataW    = DATA_W,
  localparam int IdxW    = $clog2(NumSlots)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stageEn,
  input  logic             stageIsData,
  input  logic [IdxW-1:0]  stageIdx,
  input  logic [DataW-1:0] stageVal,
  input  logic             busy,
  input  dpStrobe_t        strobe,
  output logic             anyDirty,
  output logic             ramWe,
  output logic [AddrW-1:0] ramAddr,
  output logic [DataW-1:0] ramData
);
  logic [AddrW-1:0] slotAddr [NumSlots];
  logic [DataW-1:0] slotData [NumSlots];
  logic             dirtyArr [NumSlots];
  logic [NumSlots-1:0] dirty;
  logic [IdxW-1:0]  pickIdx;
  logic [IdxW-1:0]  lastSlot;

  always_comb begin
    for (int i = 0; i < NumSlots; i++) dirty[i] = dirtyArr[i];
  end

  // lowest dirty slot wins
  always_comb begin
    pickIdx = '0;
    for (int i = NumSlots - 1; i >= 0; i--) begin
      if (dirty[i]) pickIdx = IdxW'(i);
    end
  end

  assign anyDirty = |dirty;

  for (genvar s = 0; s < NumSlots; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotAddr[s] <= '0;
        slotData[s] <= '0;
        dirtyArr[s] <= 1'b0;
      end else begin
        if (stageEn && stageIdx == IdxW'(s)) begin
          if (stageIsData) begin
            slotData[s] <= stageVal;
            dirtyArr[s] <= 1'b1;
          end else begin
            slotAddr[s] <= stageVal[AddrW-1:0];
          end
        end
        if (strobe.clearAll) dirtyArr[s] <= 1'b0;
        else if (strobe.issue && pickIdx == IdxW'(s)) dirtyArr[s] <= 1'b0;
      end
    end

    // R8: staged contents frozen while a transfer owns the slots
    p_slot_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
      busy |=> ($stable(slotAddr[s]) && $stable(slotData[s])));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramWe    <= 1'b0;
      ramAddr  <= '0;
      ramData  <= '0;
      lastSlot <= '0;
    end else begin
      ramWe <= strobe.issue;
      if (strobe.issue) begin
        ramAddr  <= slotAddr[pickIdx];
        ramData  <= slotData[pickIdx];
        lastSlot <= pickIdx;
      end
    end
  end

  // R7: back-to-back RAM writes walk the slots upward
  p_ascending_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && $past(ramWe)) |-> (lastSlot > $past(lastSlot)));

  // R4: nothing left dirty once the end-of-transfer strobe has fired
  p_dirty_cleared_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> !anyDirty);
endmodule

// File: rtl/safeload_control.sv
module safeload_control
  import safeload_pkg::*;
#(
  parameter int CtrlW    = CTRL_W,
  parameter int StartBit = START_BIT
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWrEn,
  input  logic [CtrlW-1:0] ctrlVal,
  input  logic             frameStrobe,
  input  logic             anyDirty,
  output dpStrobe_t        strobe,
  output logic [CtrlW-1:0] ctrlReg,
  output logic             busy,
  output logic             done
);
  localparam logic [CtrlW-1:0] StartMask = CtrlW'(1) << StartBit;

  xferState_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ctrlReg <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ctrlWrEn) begin
            ctrlReg <= ctrlVal;
            if (ctrlVal[StartBit]) state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (frameStrobe) state <= ST_COPY;
        end
        ST_COPY: begin
          if (!anyDirty) begin
            state             <= ST_IDLE;
            ctrlReg[StartBit] <= 1'b0;
            done              <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.issue    = (state == ST_COPY) && anyDirty;
    strobe.clearAll = (state == ST_COPY) && !anyDirty;
  end

  assign busy = (state != ST_IDLE);

  // R2: an accepted start write raises busy on the next cycle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && ctrlWrEn && ctrlVal[StartBit]) |=> busy);

  // R3: the start bit only falls together with the completion pulse
  p_selfclear_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlReg[StartBit]) |-> (done && !busy));

  // R5: other control bits untouched by the self-clear
  p_keep_bits_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((ctrlReg & ~StartMask) == ($past(ctrlReg) & ~StartMask)));

  // R6: the copy phase is entered only on a frame boundary
  p_wait_frame_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_WAIT && !$past(frameStrobe)) |-> (state != ST_COPY));
endmodule

// File: rtl/safeload_ctrl.sv
module safeload_ctrl
  import safeload_pkg::*;
#(
  parameter int NumSlots = NUM_SLOTS,
  parameter int AddrW    = ADDR_W,
  parameter int DataW    = DATA_W,
  parameter int CtrlW    = CTRL_W,
  parameter int StartBit = START_BIT,
  localparam int IdxW    = $clog2(NumSlots),
  localparam int SelW    = IdxW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [SelW-1:0]  regSel,
  input  logic [DataW-1:0] regWrData,
  output logic             regWrReady,
  input  logic             frameStrobe,
  output logic [CtrlW-1:0] ctrlReg,
  output logic             busy,
  output logic             done,
  output logic             ramWe,
  output logic [AddrW-1:0] ramAddr,
  output logic [DataW-1:0] ramData
);
  logic      accepted;
  logic      ctrlWrEn;
  logic      stageEn;
  logic      anyDirty;
  dpStrobe_t strobe;

  assign regWrReady = !busy;
  assign accepted   = regWrEn && regWrReady;
  assign ctrlWrEn   = accepted && (regSel == {SelW{1'b1}});
  assign stageEn    = accepted && (int'(regSel[IdxW-1:0]) < NumSlots);

  safeload_control #(
    .CtrlW   (CtrlW),
    .StartBit(StartBit)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlVal    (regWrData[CtrlW-1:0]),
    .frameStrobe(frameStrobe),
    .anyDirty   (anyDirty),
    .strobe     (strobe),
    .ctrlReg    (ctrlReg),
    .busy       (busy),
    .done       (done)
  );

  safeload_datapath #(
    .NumSlots(NumSlots),
    .AddrW   (AddrW),
    .DataW   (DataW)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .stageEn    (stageEn),
    .stageIsData(regSel[SelW-1]),
    .stageIdx   (regSel[IdxW-1:0]),
    .stageVal   (regWrData),
    .busy       (busy),
    .strobe     (strobe),
    .anyDirty   (anyDirty),
    .ramWe      (ramWe),
    .ramAddr    (ramAddr),
    .ramData    (ramData)
  );

  // R6: RAM writes confined to the busy window
  p_ram_in_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> busy);

  // R3: completion pulse lasts one cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: tb/safeload_ctrl_tb.sv
module safeload_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regSel = '0;
  logic [27:0] regWrData = '0;
  logic        regWrReady;
  logic        frameStrobe = 1'b0;
  logic [15:0] ctrlReg;
  logic        busy, done, ramWe;
  logic [9:0]  ramAddr;
  logic [27:0] ramData;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  safeload_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regWrReady(regWrReady), .frameStrobe(frameStrobe),
    .ctrlReg(ctrlReg), .busy(busy), .done(done), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramData(ramData)
  );

  // simple synchronous parameter RAM plus a write log
  logic [27:0] pram [1024];
  logic [9:0]  logA [8];
  logic [27:0] logD [8];
  int          logC [8];
  int          logCnt = 0;
  int          cyc = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (ramWe) begin
      pram[ramAddr] <= ramData;
      if (logCnt < 8) begin
        logA[logCnt] = ramAddr;
        logD[logCnt] = ramData;
        logC[logCnt] = cyc;
      end
      logCnt = logCnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] sel, input logic [27:0] val);
    @(negedge clk);
    while (!regWrReady) @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // start, hold off the frame for a while, pulse it, wait for done
  task automatic runXfer(input logic [15:0] ctrlVal);
    bit seen;
    logCnt = 0;
    wrReg(4'hF, {12'h0, ctrlVal});
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    repeat (6) @(negedge clk);
    chk(logCnt == 0, "R6 no RAM write before frame", logCnt, 0);
    chk(ctrlReg[6] == 1'b1, "R3 start bit held while waiting", ctrlReg[6], 1);
    frameStrobe = 1'b1;
    @(negedge clk);
    frameStrobe = 1'b0;
    seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      if (done) seen = 1; else @(negedge clk);
    end
    chk(seen, "R3 done pulse", seen, 1);
    chk(ctrlReg == (ctrlVal & 16'hFFBF), "R3 R5 control after self-clear",
        ctrlReg, ctrlVal & 16'hFFBF);
    chk(busy == 1'b0, "R3 busy low at done", busy, 0);
    @(negedge clk);
  endtask

  // {mask[4:0], addrBase[9:0], dataBase[27:0]}
  localparam logic [42:0] VEC [5] = '{
    {5'b11111, 10'h100, 28'h0A00000},
    {5'b00101, 10'h200, 28'h0B12345},
    {5'b10000, 10'h3F0, 28'hFFFFFF0},
    {5'b00000, 10'h050, 28'h0000001},
    {5'b01010, 10'h000, 28'h8000000}
  };

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(ctrlReg == 16'h0, "R10 ctrlReg reset", ctrlReg, 0);
    chk(!busy && !done && !ramWe, "R10 busy/done/ramWe reset", {busy, done, ramWe}, 0);
    chk(regWrReady == 1'b1, "R10 ready after reset", regWrReady, 1);

    for (int v = 0; v < 5; v++) begin
      logic [4:0]  mask;
      logic [9:0]  aB;
      logic [27:0] dB;
      int          expN;
      int          k;
      logic [15:0] cv;
      mask = VEC[v][42:38]; aB = VEC[v][37:28]; dB = VEC[v][27:0];
      expN = $countones(mask);
      for (int s = 0; s < 5; s++) begin
        if (mask[s]) begin
          wrReg(4'(s), {18'h0, aB + 10'(s * 3)});
          wrReg(4'(8 + s), dB + 28'(s * 'h111));
        end
      end
      cv = 16'h0040 | 16'(v << 8) | 16'h0005;
      runXfer(cv);
      chk(logCnt == expN, "R4 R9 RAM write count", logCnt, expN);
      k = 0;
      for (int s = 0; s < 5; s++) begin
        if (mask[s] && k < 8) begin
          chk(logA[k] == aB + 10'(s * 3), "R7 RAM address order", logA[k], aB + 10'(s * 3));
          chk(logD[k] == dB + 28'(s * 'h111), "R7 RAM data", logD[k], dB + 28'(s * 'h111));
          chk(pram[logA[k]] == dB + 28'(s * 'h111), "R7 RAM content",
              pram[logA[k]], dB + 28'(s * 'h111));
          if (k > 0) chk(logC[k] == logC[k-1] + 1, "R7 consecutive writes", logC[k], logC[k-1] + 1);
          k++;
        end
      end
    end

    // R4 address-only write and R1 out-of-range selects produce no RAM write
    wrReg(4'd1, 28'h155);
    wrReg(4'd5, 28'h1234567);
    wrReg(4'd13, 28'h7654321);
    wrReg(4'd14, 28'h0ABCDEF);
    runXfer(16'h0040);
    chk(logCnt == 0, "R4 R1 address-only or invalid select not copied", logCnt, 0);

    // R5 control write without the start bit
    wrReg(4'hF, 28'h0001234);
    repeat (3) @(negedge clk);
    chk(!busy && ctrlReg == 16'h1234, "R5 store without start", ctrlReg, 16'h1234);

    // R8 write attempted while busy is ignored
    wrReg(4'd0, 28'h011);
    wrReg(4'd8, 28'h0C0FFEE);
    wrReg(4'd2, 28'h022);
    logCnt = 0;
    wrReg(4'hF, 28'h0000040);
    regWrEn = 1'b1; regSel = 4'd10; regWrData = 28'h0DEAD00;
    chk(regWrReady == 1'b0, "R8 ready low while busy", regWrReady, 0);
    @(negedge clk);
    regWrEn = 1'b0;
    frameStrobe = 1'b1;
    @(negedge clk);
    frameStrobe = 1'b0;
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    chk(done == 1'b1, "R8 transfer finished", done, 1);
    chk(logCnt == 1, "R8 only slot 0 copied", logCnt, 1);
    chk(logA[0] == 10'h011 && logD[0] == 28'h0C0FFEE, "R8 slot 0 contents", logD[0], 28'h0C0FFEE);
    @(negedge clk);
    runXfer(16'h0040);
    chk(logCnt == 0, "R8 R9 blocked write left slot clean", logCnt, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule